// File: doc/BRIEF.md
# Hardware-State Flag Register with Set/Clear Commands

This block holds the run-state flags and the error flags of a serial controller. Software never writes a flag directly. Instead it writes a 16-bit command word in which every flag owns one bit that clears it and one bit that sets it. A single flag can therefore be changed without reading the register first. All bits that are left at zero leave their flags untouched.

The controller's data path reports error events on `hw_evt`. Each event raises its flag only while the matching bit of `err_en` is on. The five error flags and the mode-error flag are ORed together, and the result is gated by `irq_en` to form one error interrupt request. There are two flags for the run state. The enable flag selects run mode (1) or configuration mode (0). The master-select flag is the second.

Going back to configuration mode is unsafe while the data path is busy. A clear-enable command given while `busy_i` is high is therefore held back. It takes effect on the first clock edge at which `busy_i` is low, unless a later set-enable command cancels it. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `hwstate_ctrl`

## Requirements
- R1: After reset, every flag is 0, so `status_o` reads 0x0000 (with `busy_i` low), `mode_err_o` is 0 and `err_irq_o` is 0.
- R2: A command with bit 1 set puts enable (status bit 0) to 1. A command with bit 0 set clears it. The flag updates at the clock edge that samples the write.
- R3: Command bit 3 sets master select (status bit 1) and command bit 2 clears it.
- R4: The error flags use this command and status encoding. Command bits 12..15 set, and bits 8..11 clear, the transmit-overflow, receive-overflow, abort and transmit-underflow flags, which appear at status bits 8, 9, 10 and 11. Command bit 5 sets, and bit 4 clears, the receive-underflow flag at status bit 12.
- R5: Command bit 7 sets the mode-error flag and bit 6 clears it. The flag is visible on `mode_err_o`.
- R6: When the set bit and the clear bit of the same flag are written together, the flag ends at 0.
- R7: `hw_evt[i]` sets error flag i (order: transmit overflow, receive overflow, abort, transmit underflow, receive underflow) only while `err_en[i]` is 1. With `err_en[i]` at 0 the event has no effect.
- R8: An enabled hardware event and a software clear of the same flag in the same cycle leave the flag at 1.
- R9: The command 0x0F50 clears all five error flags and the mode-error flag, and leaves enable and master select unchanged.
- R10: A clear-enable command taken while `busy_i` is 1 leaves enable at 1. Enable falls at the first later edge with `busy_i` low, unless a set-enable command arrives first. A set-enable command cancels the pending clear.
- R11: `err_irq_o` equals `irq_en` AND (any error flag OR mode error), in the same cycle as the flags.
- R12: Status bit 13 follows `busy_i` in the same cycle. Status bits 2..7, 14 and 15 read 0.
- R13: While `cmd_valid` is 0, the value of `cmd_word` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word is written in this cycle |
| cmd_word | input | 16 | Set/clear command bits |
| err_en | input | 5 | Per-error capture enables |
| hw_evt | input | 5 | Per-error hardware event pulses |
| busy_i | input | 1 | Data path transfer in progress |
| irq_en | input | 1 | Error interrupt enable |
| status_o | output | 16 | Readable status word |
| mode_err_o | output | 1 | Mode-error flag |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
A command or an enabled event is sampled on a rising edge, and the flags it changes show on `status_o` and `mode_err_o` directly after that same edge: a latency of one cycle. `err_irq_o` and status bit 13 are combinational, so they follow their inputs within the same cycle. A deferred clear of enable lands one edge after `busy_i` is first seen low. The bench drives every input on the falling edge. It moves its reference model on the rising edge and compares all outputs on the next falling edge, so each result is sampled exactly one edge after its cause, or in the same cycle for the combinational outputs.

// File: rtl/hwstate_pkg.sv
package hwstate_pkg;
  localparam int CMD_W   = 16;
  localparam int STAT_W  = 16;
  localparam int NUM_ERR = 5;

  // command word positions of the run-state and mode flags
  localparam int C_CLR_EN = 0;
  localparam int C_SET_EN = 1;
  localparam int C_CLR_MS = 2;
  localparam int C_SET_MS = 3;
  localparam int C_CLR_ME = 6;
  localparam int C_SET_ME = 7;

  // status word positions
  localparam int S_EN      = 0;
  localparam int S_MS      = 1;
  localparam int S_ERR_LSB = 8;
  localparam int S_BUSY    = 13;

  // error i: 0 tx overflow, 1 rx overflow, 2 abort, 3 tx underflow, 4 rx underflow
  function automatic int err_clr_pos(input int i);
    return (i < 4) ? (8 + i) : 4;
  endfunction

  function automatic int err_set_pos(input int i);
    return (i < 4) ? (12 + i) : 5;
  endfunction
endpackage

// File: rtl/hwstate_flag.sv
module hwstate_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic set_b,
  input  logic clr_b,
  input  logic evt,
  output logic q
);
  // priority: hardware event, then clear, then set
  always_ff @(posedge clk) begin
    if (!rst_n)            q <= RST_VAL;
    else if (evt)          q <= 1'b1;
    else if (wr && clr_b)  q <= 1'b0;
    else if (wr && set_b)  q <= 1'b1;
  end
endmodule

// File: rtl/hwstate_run_ctrl.sv
module hwstate_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic set_b,
  input  logic clr_b,
  input  logic busy,
  output logic en
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      pend_q <= 1'b0;
    end else if (wr && clr_b) begin
      if (busy) begin
        pend_q <= 1'b1;
      end else begin
        en     <= 1'b0;
        pend_q <= 1'b0;
      end
    end else if (wr && set_b) begin
      en     <= 1'b1;
      pend_q <= 1'b0;
    end else if (pend_q && !busy) begin
      en     <= 1'b0;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hwstate_irq.sv
module hwstate_irq #(
  parameter int N = 6
) (
  input  logic [N-1:0] flags,
  input  logic         irq_en,
  output logic         irq
);
  assign irq = irq_en & (|flags);
endmodule

// File: rtl/hwstate_ctrl.sv
module hwstate_ctrl
  import hwstate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [NUM_ERR-1:0] err_en,
  input  logic [NUM_ERR-1:0] hw_evt,
  input  logic              busy_i,
  input  logic              irq_en,
  output logic [STAT_W-1:0] status_o,
  output logic              mode_err_o,
  output logic              err_irq_o
);
  logic               en_q;
  logic               ms_q;
  logic [NUM_ERR-1:0] err_q;

  hwstate_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .wr(cmd_valid),
    .set_b(cmd_word[C_SET_EN]), .clr_b(cmd_word[C_CLR_EN]),
    .busy(busy_i), .en(en_q)
  );

  hwstate_flag u_ms (
    .clk(clk), .rst_n(rst_n), .wr(cmd_valid),
    .set_b(cmd_word[C_SET_MS]), .clr_b(cmd_word[C_CLR_MS]),
    .evt(1'b0), .q(ms_q)
  );

  hwstate_flag u_me (
    .clk(clk), .rst_n(rst_n), .wr(cmd_valid),
    .set_b(cmd_word[C_SET_ME]), .clr_b(cmd_word[C_CLR_ME]),
    .evt(1'b0), .q(mode_err_o)
  );

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    localparam int SP = err_set_pos(i);
    localparam int CP = err_clr_pos(i);
    hwstate_flag u_f (
      .clk(clk), .rst_n(rst_n), .wr(cmd_valid),
      .set_b(cmd_word[SP]), .clr_b(cmd_word[CP]),
      .evt(hw_evt[i] & err_en[i]), .q(err_q[i])
    );
  end

  hwstate_irq #(.N(NUM_ERR + 1)) u_irq (
    .flags({mode_err_o, err_q}), .irq_en(irq_en), .irq(err_irq_o)
  );

  always_comb begin
    status_o = '0;
    status_o[S_EN] = en_q;
    status_o[S_MS] = ms_q;
    status_o[S_ERR_LSB +: NUM_ERR] = err_q;
    status_o[S_BUSY] = busy_i;
  end
endmodule

// File: rtl/hwstate_ctrl_chk.sv
module hwstate_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [15:0] cmd_word,
  input logic [4:0]  err_en,
  input logic [4:0]  hw_evt,
  input logic        busy_i,
  input logic        irq_en,
  input logic [15:0] status_o,
  input logic        mode_err_o,
  input logic        err_irq_o
);
  a_r2_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[1] && !cmd_word[0] |=> status_o[0]);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[3] && cmd_word[2] |=> !status_o[1]);

  a_r7_no_capture_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && hw_evt[0] && !err_en[0] && !status_o[8] |=> !status_o[8]);

  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt[2] && err_en[2] |=> status_o[10]);

  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word == 16'h0F50 && hw_evt == 5'd0
    |=> status_o[12:8] == 5'd0 && !mode_err_o);

  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[0] && busy_i && status_o[0] |=> status_o[0]);

  a_r11_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o == (irq_en && ((|status_o[12:8]) || mode_err_o)));

  a_r13_idle_master_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(status_o[1]));
endmodule

bind hwstate_ctrl hwstate_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .err_en(err_en), .hw_evt(hw_evt), .busy_i(busy_i), .irq_en(irq_en),
  .status_o(status_o), .mode_err_o(mode_err_o), .err_irq_o(err_irq_o)
);

// File: tb/hwstate_ctrl_tb.sv
module hwstate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic [4:0]  err_en, hw_evt;
  logic        busy_i, irq_en;
  logic [15:0] status_o;
  logic        mode_err_o, err_irq_o;

  int checks = 0;
  int failures = 0;

  // reference model state
  int m_en, m_ms, m_me, m_pend;
  int m_err[5];

  always #(CLK_PERIOD/2) clk = ~clk;

  hwstate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .err_en(err_en), .hw_evt(hw_evt), .busy_i(busy_i), .irq_en(irq_en),
    .status_o(status_o), .mode_err_o(mode_err_o), .err_irq_o(err_irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_status();
    int s = m_en | (m_ms << 1) | (int'(busy_i) << 13);
    for (int i = 0; i < 5; i++) s |= m_err[i] << (8 + i);
    return s;
  endfunction

  function automatic int model_irq();
    int any = m_me;
    for (int i = 0; i < 5; i++) any |= m_err[i];
    return (irq_en && any) ? 1 : 0;
  endfunction

  task automatic model_edge();
    int v = cmd_valid;
    for (int i = 0; i < 5; i++) begin
      int cp = (i < 4) ? 8 + i : 4;
      int sp = (i < 4) ? 12 + i : 5;
      if (hw_evt[i] && err_en[i]) m_err[i] = 1;
      else if (v && cmd_word[cp]) m_err[i] = 0;
      else if (v && cmd_word[sp]) m_err[i] = 1;
    end
    if (v && cmd_word[2]) m_ms = 0; else if (v && cmd_word[3]) m_ms = 1;
    if (v && cmd_word[6]) m_me = 0; else if (v && cmd_word[7]) m_me = 1;
    if (v && cmd_word[0]) begin
      if (busy_i) m_pend = 1; else begin m_en = 0; m_pend = 0; end
    end else if (v && cmd_word[1]) begin
      m_en = 1; m_pend = 0;
    end else if (m_pend && !busy_i) begin
      m_en = 0; m_pend = 0;
    end
  endtask

  // drive on the falling edge, advance model on rising, compare on next falling
  task automatic step(input logic v, input logic [15:0] w, input logic [4:0] ev,
                      input logic [4:0] een, input logic b, input logic ie);
    cmd_valid = v; cmd_word = w; hw_evt = ev; err_en = een; busy_i = b; irq_en = ie;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2/R3/R4/R10/R12 status vs model", int'(status_o), model_status());
    chk("R5 mode error vs model", int'(mode_err_o), m_me);
    chk("R11 irq vs model", int'(err_irq_o), model_irq());
  endtask

  task automatic idle(input logic b, input logic ie);
    step(1'b0, 16'h0, 5'h0, 5'h0, b, ie);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 0; cmd_word = 0; hw_evt = 0; err_en = 0;
    busy_i = 0; irq_en = 0;
    m_en = 0; m_ms = 0; m_me = 0; m_pend = 0;
    for (int i = 0; i < 5; i++) m_err[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", int'(status_o), 32'h0000);
    chk("R1 reset mode error", int'(mode_err_o), 0);
    chk("R1 reset irq", int'(err_irq_o), 0);

    step(1, 16'h0002, 0, 0, 0, 0);
    chk("R2 set enable", int'(status_o), 32'h0001);
    step(1, 16'h0008, 0, 0, 0, 0);
    chk("R3 set master", int'(status_o), 32'h0003);
    step(1, 16'h0004, 0, 0, 0, 0);
    chk("R3 clear master", int'(status_o), 32'h0001);
    step(1, 16'h0008, 0, 0, 0, 0);
    step(1, 16'hF020, 0, 0, 0, 0);
    chk("R4 set all errors", int'(status_o), 32'h1F03);
    chk("R11 irq gated off", int'(err_irq_o), 0);
    irq_en = 1'b1; #1;
    chk("R11 irq same cycle", int'(err_irq_o), 1);
    step(1, 16'h0210, 0, 0, 0, 1);
    chk("R4 clear rx overflow and rx underflow", int'(status_o), 32'h0D03);
    step(1, 16'h0080, 0, 0, 0, 1);
    chk("R5 set mode error", int'(mode_err_o), 1);
    step(1, 16'h0F50, 0, 0, 0, 1);
    chk("R9 clear all errors", int'(status_o), 32'h0003);
    chk("R9 mode error cleared", int'(mode_err_o), 0);
    chk("R11 irq low after clear", int'(err_irq_o), 0);
    step(1, 16'h000C, 0, 0, 0, 0);
    chk("R6 clear wins", int'(status_o), 32'h0001);
    step(1, 16'h0003, 0, 0, 0, 0);
    chk("R6 enable clear wins", int'(status_o), 32'h0000);
    step(1, 16'h0002, 0, 0, 0, 0);
    step(0, 16'hFFFF, 0, 0, 0, 0);
    chk("R13 no write without valid", int'(status_o), 32'h0001);
    step(0, 16'h0000, 5'h1F, 5'h00, 0, 0);
    chk("R7 events ignored when disabled", int'(status_o), 32'h0001);
    step(0, 16'h0000, 5'h1F, 5'h04, 0, 0);
    chk("R7 abort captured", int'(status_o), 32'h0401);
    step(1, 16'h0100, 5'h01, 5'h01, 0, 0);
    chk("R8 event beats clear", int'(status_o), 32'h0501);
    step(1, 16'h0F50, 0, 0, 0, 0);
    chk("R9 enable kept", int'(status_o), 32'h0001);
    step(1, 16'h0001, 0, 0, 1, 0);
    chk("R10 clear held while busy", int'(status_o), 32'h2001);
    chk("R12 busy bit", int'(status_o[13]), 1);
    idle(1, 0);
    chk("R10 still held", int'(status_o), 32'h2001);
    idle(0, 0);
    chk("R10 clear lands when idle", int'(status_o), 32'h0000);
    step(1, 16'h0002, 0, 0, 0, 0);
    step(1, 16'h0001, 0, 0, 1, 0);
    step(1, 16'h0002, 0, 0, 1, 0);
    idle(0, 0);
    chk("R10 set cancels pending clear", int'(status_o), 32'h0001);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] q = $urandom;
      step(r[1:0] == 2'b00, q[15:0], (r[6:2] & r[11:7]), r[16:12], r[17], r[18]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule